// File: doc/BRIEF.md
# CPU Operating State Controller

This block tracks which operating state a small processor core occupies. The eight states are power-on reset, manual reset, hardware standby, exception handling, program execution, bus released, sleep and software standby. It watches three active-low pins: power-on reset, manual reset and standby. It also watches a set of on-chip strobes and requests: a watchdog overflow pulse, a sleep-instruction strobe with a standby-select bit, bus, interrupt and external interrupt requests, and exception start/done strobes. From these it reports a one-hot state vector with halt, interrupt-mask and bus-grant qualifiers.

The three pins are taken in through per-pin synchronizer chains. Each chain clears asynchronously when its own pin falls and fills with ones after the pin rises. A pin therefore takes effect at once when asserted, and its release is seen only after the synchronizer. The power-on reset pin also resets the state register asynchronously. While the synchronized standby level is low, the shown state is forced to hardware standby. The core cannot leave that state until the reset pin is pulled low. When the bus is handed over, a one-bit register remembers whether to return to execution or to exception handling.

Top module: `cpu_state_ctl`

## Requirements
- R1: While the standby pin is low, the shown state is hardware standby from the moment it falls, whatever the other inputs do; this has the highest priority.
- R2: Pulling the reset pin low moves the state register to power-on reset at once; the shown state is power-on reset unless the standby pin is also low.
- R3: A one-cycle watchdog overflow pulse moves the controller to power-on reset on the next clock edge; with the reset pin high it goes on to exception handling on the edge after.
- R4: With the enable bit set, the manual-reset pin low enters manual reset on the next edge from any state but hardware standby and power-on reset. With the enable bit clear the pin has no effect.
- R5: Hardware standby is left only while the standby pin is high and the reset pin is low, into power-on reset; power-on reset is shown on the second edge after the standby pin rises. With the reset pin high the controller stays in hardware standby.
- R6: halt is high in every state except program execution and exception handling; intMask is high in power-on reset, manual reset and hardware standby; busGrant is high only in bus released.
- R7: The third clock edge after the reset pin rises (or the manual-reset pin rises while in manual reset) moves the controller to exception handling.
- R8: A sleep strobe in program execution enters sleep when stbySelect is 0 and software standby when it is 1.
- R9: intReq wakes sleep and extIntReq wakes software standby, both into exception handling; in each of these two states the other request has no effect.
- R10: busReq in program execution or exception handling enters bus released; when busReq drops, the controller returns to the state it left.
- R11: excReq in program execution enters exception handling and excDone returns it to program execution; in program execution busReq takes priority over a sleep strobe, and a sleep strobe over excReq.
- R12: stateVec is one-hot with bit 0 power-on reset, 1 manual reset, 2 hardware standby, 3 exception handling, 4 program execution, 5 bus released, 6 sleep, 7 software standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset pin, active low |
| mrstN | input | 1 | Manual reset pin, active low |
| stbyN | input | 1 | Hardware standby pin, active low |
| mrstEnable | input | 1 | Allows the manual reset pin to act |
| wdtOverflow | input | 1 | Watchdog overflow pulse |
| sleepStrobe | input | 1 | Sleep instruction executed |
| stbySelect | input | 1 | 0 selects sleep, 1 selects software standby |
| busReq | input | 1 | External bus request |
| intReq | input | 1 | Interrupt request |
| extIntReq | input | 1 | External interrupt request |
| excReq | input | 1 | Exception handling request |
| excDone | input | 1 | Exception handling finished |
| stateVec | output | 8 | One-hot current state |
| halt | output | 1 | Execution halted |
| intMask | output | 1 | All interrupts masked |
| busGrant | output | 1 | Bus handed to the requester |

## Verification
Pin assertions act with no clock edge at all. Standby and reset show in the same cycle, and manual reset shows on the first edge. Pin releases need two edges to pass the synchronizer, so standby release shows on the second edge and reset release reaches exception handling on the third. Strobes and requests act on the first edge after they are presented. The bench drives inputs just after the falling edge, and its reference model advances on the rising edge using the same pin delays. All outputs are compared on every falling edge, so each of these latencies is checked in exactly the cycle it is due.

// File: rtl/cpu_state_pkg.sv
package cpu_state_pkg;

  typedef enum logic [2:0] {
    ST_POR    = 3'd0,
    ST_MRST   = 3'd1,
    ST_HWSTBY = 3'd2,
    ST_EXC    = 3'd3,
    ST_EXEC   = 3'd4,
    ST_BUSREL = 3'd5,
    ST_SLEEP  = 3'd6,
    ST_SWSTBY = 3'd7
  } opState_e;

  localparam int NUM_STATES = 8;
  localparam int PIN_COUNT  = 3;
  localparam int PIN_RST    = 0;
  localparam int PIN_MRST   = 1;
  localparam int PIN_STBY   = 2;

  typedef struct packed {
    logic saveRet;
    logic retExc;
  } ctlStrobe_t;

endpackage

// File: rtl/cpu_state_dp.sv
module cpu_state_dp
  import cpu_state_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinN,
  input  ctlStrobe_t           strobe,
  output logic [PIN_COUNT-1:0] pinSync,
  output logic                 savedRetExc
);

  localparam int LAST = SYNC_STAGES - 1;

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge pinN[p]) begin
      if (!pinN[p]) chain <= '0;
      else          chain <= {chain[LAST-1:0], 1'b1};
    end
    assign pinSync[p] = chain[LAST];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               savedRetExc <= 1'b0;
    else if (strobe.saveRet) savedRetExc <= strobe.retExc;
  end

endmodule

// File: rtl/cpu_state_fsm.sv
module cpu_state_fsm
  import cpu_state_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rstSync,
  input  logic                  mrstSync,
  input  logic                  stbySync,
  input  logic                  savedRetExc,
  input  logic                  mrstEnable,
  input  logic                  wdtOverflow,
  input  logic                  sleepStrobe,
  input  logic                  stbySelect,
  input  logic                  busReq,
  input  logic                  intReq,
  input  logic                  extIntReq,
  input  logic                  excReq,
  input  logic                  excDone,
  output ctlStrobe_t            strobe,
  output logic [NUM_STATES-1:0] stateVec,
  output logic                  halt,
  output logic                  intMask,
  output logic                  busGrant
);

  opState_e stateQ, nextState, shownState;
  logic     mrstHit;

  assign mrstHit = mrstEnable && !mrstSync;

  always_comb begin
    nextState = stateQ;
    strobe    = '0;
    if (!stbySync)                   nextState = ST_HWSTBY;
    else if (stateQ == ST_HWSTBY)    nextState = ST_HWSTBY;
    else if (!rstSync || wdtOverflow) nextState = ST_POR;
    else if (mrstHit && stateQ != ST_POR) nextState = ST_MRST;
    else begin
      case (stateQ)
        ST_POR:  nextState = ST_EXC;
        ST_MRST: if (mrstSync) nextState = ST_EXC;
        ST_EXEC: begin
          if (busReq) begin
            nextState      = ST_BUSREL;
            strobe.saveRet = 1'b1;
            strobe.retExc  = 1'b0;
          end else if (sleepStrobe) begin
            nextState = stbySelect ? ST_SWSTBY : ST_SLEEP;
          end else if (excReq) begin
            nextState = ST_EXC;
          end
        end
        ST_EXC: begin
          if (busReq) begin
            nextState      = ST_BUSREL;
            strobe.saveRet = 1'b1;
            strobe.retExc  = 1'b1;
          end else if (excDone) begin
            nextState = ST_EXEC;
          end
        end
        ST_BUSREL: if (!busReq) nextState = savedRetExc ? ST_EXC : ST_EXEC;
        ST_SLEEP:  if (intReq) nextState = ST_EXC;
        ST_SWSTBY: if (extIntReq) nextState = ST_EXC;
        default:   nextState = stateQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_POR;
    else       stateQ <= nextState;
  end

  assign shownState = stbySync ? stateQ : ST_HWSTBY;
  assign stateVec   = NUM_STATES'(1) << shownState;
  assign halt       = !(shownState == ST_EXEC || shownState == ST_EXC);
  assign intMask    = shownState == ST_POR || shownState == ST_MRST ||
                      shownState == ST_HWSTBY;
  assign busGrant   = shownState == ST_BUSREL;

  AST_STBY_OVERRIDE: assert property (@(posedge clk) disable iff (!rstN)
    !stbySync |=> stateQ == ST_HWSTBY); // R1
  AST_WDT_TO_POR: assert property (@(posedge clk) disable iff (!rstN)
    (wdtOverflow && stbySync && stateQ != ST_HWSTBY) |=> stateQ == ST_POR); // R3
  AST_MRST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!mrstEnable && stateQ != ST_MRST) |=> stateQ != ST_MRST); // R4
  AST_RESET_MASKS: assert property (@(posedge clk)
    (stateVec[int'(ST_POR)] || stateVec[int'(ST_MRST)]) |-> (halt && intMask)); // R6
  AST_SWSTBY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SWSTBY && !extIntReq && stbySync && rstSync && !wdtOverflow && !mrstHit)
    |=> stateQ == ST_SWSTBY); // R9
  AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busGrant) |-> $past(busReq)); // R10
  AST_ONE_HOT: assert property (@(posedge clk)
    $countones(stateVec) == 1); // R12

endmodule

// File: rtl/cpu_state_ctl.sv
module cpu_state_ctl
  import cpu_state_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mrstN,
  input  logic       stbyN,
  input  logic       mrstEnable,
  input  logic       wdtOverflow,
  input  logic       sleepStrobe,
  input  logic       stbySelect,
  input  logic       busReq,
  input  logic       intReq,
  input  logic       extIntReq,
  input  logic       excReq,
  input  logic       excDone,
  output logic [7:0] stateVec,
  output logic       halt,
  output logic       intMask,
  output logic       busGrant
);

  logic [PIN_COUNT-1:0] pinN, pinSync;
  ctlStrobe_t           strobe;
  logic                 savedRetExc;

  assign pinN[PIN_RST]  = rstN;
  assign pinN[PIN_MRST] = mrstN;
  assign pinN[PIN_STBY] = stbyN;

  cpu_state_dp #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .pinN(pinN), .strobe(strobe),
    .pinSync(pinSync), .savedRetExc(savedRetExc)
  );

  cpu_state_fsm i_fsm (
    .clk(clk), .rstN(rstN),
    .rstSync(pinSync[PIN_RST]), .mrstSync(pinSync[PIN_MRST]),
    .stbySync(pinSync[PIN_STBY]), .savedRetExc(savedRetExc),
    .mrstEnable(mrstEnable), .wdtOverflow(wdtOverflow),
    .sleepStrobe(sleepStrobe), .stbySelect(stbySelect),
    .busReq(busReq), .intReq(intReq), .extIntReq(extIntReq),
    .excReq(excReq), .excDone(excDone), .strobe(strobe),
    .stateVec(stateVec), .halt(halt), .intMask(intMask), .busGrant(busGrant)
  );

endmodule

// File: tb/test_cpu_state_ctl.sv
`timescale 1ns/1ps
module test_cpu_state_ctl;

  logic clk = 1'b0;
  logic rstN = 1'b0, mrstN = 1'b1, stbyN = 1'b0;
  logic mrstEnable = 1'b0, wdtOverflow = 1'b0, sleepStrobe = 1'b0, stbySelect = 1'b0;
  logic busReq = 1'b0, intReq = 1'b0, extIntReq = 1'b0, excReq = 1'b0, excDone = 1'b0;
  logic [7:0] stateVec;
  logic halt, intMask, busGrant;

  int compared = 0, mismatched = 0, cycles = 0;
  bit finished = 1'b0;
  string curReq = "R12";

  // reference model: state numbers follow the bit positions of R12
  int mSt = 0;
  bit mRet = 1'b0;
  logic [1:0] rH = 2'b00, mH = 2'b00, sH = 2'b00;

  always #10 clk = ~clk;

  cpu_state_ctl i_cpu_state_ctl (
    .clk(clk), .rstN(rstN), .mrstN(mrstN), .stbyN(stbyN),
    .mrstEnable(mrstEnable), .wdtOverflow(wdtOverflow),
    .sleepStrobe(sleepStrobe), .stbySelect(stbySelect),
    .busReq(busReq), .intReq(intReq), .extIntReq(extIntReq),
    .excReq(excReq), .excDone(excDone),
    .stateVec(stateVec), .halt(halt), .intMask(intMask), .busGrant(busGrant)
  );

  always @(negedge rstN) begin mSt = 0; rH = 2'b00; mRet = 1'b0; end
  always @(negedge mrstN) mH = 2'b00;
  always @(negedge stbyN) sH = 2'b00;

  always @(posedge clk) begin
    int nx;
    bit mHit;
    nx = mSt;
    mHit = mrstEnable && !mH[1];
    if (!sH[1]) nx = 2;
    else if (mSt == 2) nx = 2;
    else if (!rH[1] || wdtOverflow) nx = 0;
    else if (mHit && mSt != 0) nx = 1;
    else if (mSt == 0) nx = 3;
    else if (mSt == 1) begin if (mH[1]) nx = 3; end
    else if (mSt == 4) begin
      if (busReq) begin nx = 5; mRet = 1'b0; end
      else if (sleepStrobe) nx = stbySelect ? 7 : 6;
      else if (excReq) nx = 3;
    end
    else if (mSt == 3) begin
      if (busReq) begin nx = 5; mRet = 1'b1; end
      else if (excDone) nx = 4;
    end
    else if (mSt == 5) begin if (!busReq) nx = mRet ? 3 : 4; end
    else if (mSt == 6) begin if (intReq) nx = 3; end
    else if (mSt == 7) begin if (extIntReq) nx = 3; end
    mSt = rstN ? nx : 0;
    rH = rstN  ? {rH[0], 1'b1} : 2'b00;
    mH = mrstN ? {mH[0], 1'b1} : 2'b00;
    sH = stbyN ? {sH[0], 1'b1} : 2'b00;
  end

  task automatic checkBit(string name, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", curReq, name, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      int shown;
      shown = sH[1] ? mSt : 2;
      checkBit("stateVec", stateVec, 8'(1 << shown));
      checkBit("halt", {7'd0, halt}, {7'd0, !(shown == 3 || shown == 4)});
      checkBit("intMask", {7'd0, intMask}, {7'd0, shown <= 2});
      checkBit("busGrant", {7'd0, busGrant}, {7'd0, shown == 5});
    end
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !finished) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      finish_run();
    end
  end

  initial begin
    curReq = "R1"; step(4);              // both pins low: hardware standby
    curReq = "R5"; stbyN = 1'b1; step(4); // leave standby into power-on reset
    curReq = "R7"; rstN = 1'b1; step(5);  // third edge: exception handling
    curReq = "R11"; excDone = 1'b1; step(1); excDone = 1'b0; step(2);
    curReq = "R10"; busReq = 1'b1; step(3); busReq = 1'b0; step(2);
    curReq = "R11"; excReq = 1'b1; step(1); excReq = 1'b0; step(2);
    curReq = "R10"; busReq = 1'b1; step(2); busReq = 1'b0; step(2);
    excDone = 1'b1; step(1); excDone = 1'b0; step(1);
    curReq = "R11"; busReq = 1'b1; sleepStrobe = 1'b1; excReq = 1'b1; step(1);
    sleepStrobe = 1'b0; excReq = 1'b0; step(1); busReq = 1'b0; step(2);
    sleepStrobe = 1'b1; excReq = 1'b1; step(1); sleepStrobe = 1'b0; excReq = 1'b0; step(1);
    curReq = "R9"; intReq = 1'b1; step(1); intReq = 1'b0; step(1);
    excDone = 1'b1; step(1); excDone = 1'b0; step(1);
    curReq = "R8"; sleepStrobe = 1'b1; step(1); sleepStrobe = 1'b0; step(2);
    curReq = "R9"; extIntReq = 1'b1; step(2); extIntReq = 1'b0;
    intReq = 1'b1; step(1); intReq = 1'b0; step(1);
    excDone = 1'b1; step(1); excDone = 1'b0; step(1);
    curReq = "R8"; stbySelect = 1'b1; sleepStrobe = 1'b1; step(1);
    sleepStrobe = 1'b0; stbySelect = 1'b0; step(2);
    curReq = "R9"; intReq = 1'b1; step(2); intReq = 1'b0;
    extIntReq = 1'b1; step(1); extIntReq = 1'b0; step(1);
    excDone = 1'b1; step(1); excDone = 1'b0; step(1);
    curReq = "R4"; mrstN = 1'b0; step(4); mrstEnable = 1'b1; step(3);
    curReq = "R7"; mrstN = 1'b1; step(5);
    excDone = 1'b1; step(1); excDone = 1'b0; step(1);
    curReq = "R4"; rstN = 1'b0; step(1); mrstN = 1'b0; step(4);
    mrstN = 1'b1; step(3); rstN = 1'b1; step(5); mrstEnable = 1'b0;
    excDone = 1'b1; step(1); excDone = 1'b0; step(1);
    curReq = "R3"; wdtOverflow = 1'b1; step(1); wdtOverflow = 1'b0; step(3);
    excDone = 1'b1; step(1); excDone = 1'b0; step(1);
    curReq = "R1"; busReq = 1'b1; step(2); stbyN = 1'b0; step(3); busReq = 1'b0;
    curReq = "R5"; stbyN = 1'b1; step(5);
    curReq = "R2"; rstN = 1'b0; step(3); rstN = 1'b1; step(4);
    excDone = 1'b1; step(1); excDone = 1'b0; sleepStrobe = 1'b1; step(1);
    sleepStrobe = 1'b0; step(1);
    curReq = "R2"; rstN = 1'b0; step(2); rstN = 1'b1; step(5);
    curReq = "R6"; step(2);
    finish_run();
  end

endmodule